// File: doc/BRIEF.md
# Packed Signed Lane Add/Subtract Unit

This block performs signed, lane-wise addition and subtraction on two packed 32-bit operands. It has two lane sizes. Four operations treat each operand as two signed halfwords: straight add, straight subtract, and two exchange forms that pair each half of the first operand with the opposite half of the second. Two further operations treat each operand as four signed bytes and add or subtract them lane by lane.

Each lane is computed at full precision, one bit wider than the lane. The stored lane result is the low bits of that exact value, so it wraps. A per-byte "greater or equal" flag vector records whether each exact lane result was zero or positive. A later select or merge step can read this flag vector. The result and the flags sit in registers. They change only on a clock edge where the execute enable is high and the operation code is defined. The caller decides whether to assert the enable, for example from its own condition evaluation.

Top module: `psimd_addsub_unit`

## Requirements
- R1: An active-high synchronous reset sets `res_q` and `ge_q` to zero on the next clock edge.
- R2: Code 0 (halfword add): result bits [15:0] are a[15:0]+b[15:0], and bits [31:16] are a[31:16]+b[31:16]. Both wrap to 16 bits.
- R3: Code 3 (halfword subtract): result bits [15:0] are a[15:0]-b[15:0], and bits [31:16] are a[31:16]-b[31:16]. Both wrap to 16 bits.
- R4: Code 1 (exchange, subtract low): bits [15:0] are a[15:0]-b[31:16], and bits [31:16] are a[31:16]+b[15:0].
- R5: Code 2 (exchange, add low): bits [15:0] are a[15:0]+b[31:16], and bits [31:16] are a[31:16]-b[15:0].
- R6: Code 4 (byte add): each byte lane k (k=0 at bits [7:0]) of the result is the wrapped signed sum of byte k of a and byte k of b.
- R7: Code 7 (byte subtract): each byte lane k of the result is byte k of a minus byte k of b, wrapped to 8 bits.
- R8: For codes 0 to 3, `ge_q[1:0]` are both 1 when the exact 17-bit signed low-half result is zero or positive, and both 0 otherwise. `ge_q[3:2]` follow the high half in the same way.
- R9: For codes 4 and 7, `ge_q[k]` is 1 exactly when the exact 9-bit signed result of byte lane k is zero or positive.
- R10: While `exec_en` is low, `res_q` and `ge_q` keep their values whatever the other inputs are.
- R11: Codes 5 and 6 are reserved. With `exec_en` high they leave `res_q` and `ge_q` unchanged.
- R12: An operation presented before a clock edge is visible on `res_q`/`ge_q` right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execute enable; the registers update only when it is high |
| op | input | 3 | Operation code (0-4, 7 defined; 5, 6 reserved) |
| opnd_a | input | 32 | First packed operand |
| opnd_b | input | 32 | Second packed operand |
| res_q | output | 32 | Registered packed result |
| ge_q | output | 4 | Registered per-byte greater-or-equal flags |

## Verification
The assertions check the properties that hold on every cycle. Reset clears both registers. A low enable or a reserved code holds the state. The two flag bits of a half always agree after a halfword operation. Halfword add matches a wrapped sum. A byte subtract of equal operands yields zero with every flag set. The bench scenarios cover what a property cannot state cheaply. These are the exact lane values of the exchange forms, the flag results at lane overflow, where the flag must follow the sign of the exact result and not the wrapped bit, and the one-edge latency seen from both sides of the edge.

// File: rtl/simd_pkg.sv
package simd_pkg;

  localparam int NUM_HALF = 2;

  typedef enum logic [2:0] {
    OP_H_ADD     = 3'd0,
    OP_H_XSUBADD = 3'd1,
    OP_H_XADDSUB = 3'd2,
    OP_H_SUB     = 3'd3,
    OP_B_ADD     = 3'd4,
    OP_RSV5      = 3'd5,
    OP_RSV6      = 3'd6,
    OP_B_SUB     = 3'd7
  } simd_op_e;

  typedef struct packed {
    logic                valid;
    logic                byte_mode;
    logic                xchg;
    logic [NUM_HALF-1:0] half_sub;
    logic                byte_sub;
  } simd_ctrl_t;

endpackage

// File: rtl/simd_op_decode.sv
module simd_op_decode
  import simd_pkg::*;
(
  input  logic [2:0]  op,
  output simd_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (simd_op_e'(op))
      OP_H_ADD: begin
        ctrl.valid = 1'b1;
      end
      OP_H_XSUBADD: begin
        ctrl.valid    = 1'b1;
        ctrl.xchg     = 1'b1;
        ctrl.half_sub = 2'b01;
      end
      OP_H_XADDSUB: begin
        ctrl.valid    = 1'b1;
        ctrl.xchg     = 1'b1;
        ctrl.half_sub = 2'b10;
      end
      OP_H_SUB: begin
        ctrl.valid    = 1'b1;
        ctrl.half_sub = 2'b11;
      end
      OP_B_ADD: begin
        ctrl.valid     = 1'b1;
        ctrl.byte_mode = 1'b1;
      end
      OP_B_SUB: begin
        ctrl.valid     = 1'b1;
        ctrl.byte_mode = 1'b1;
        ctrl.byte_sub  = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/simd_half_path.sv
module simd_half_path
  import simd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int HALF_W = DATA_W / NUM_HALF,
  localparam int NUM_BYTE = DATA_W / LANE_W,
  localparam int BYTES_PER_HALF = NUM_BYTE / NUM_HALF
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic                xchg,
  input  logic [NUM_HALF-1:0] sub,
  output logic [DATA_W-1:0]   res,
  output logic [NUM_BYTE-1:0] ge
);

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    localparam int OPP = NUM_HALF - 1 - h;
    logic [HALF_W-1:0] a_h, b_straight, b_cross, b_sel;
    logic [HALF_W:0]   ea, eb, exact;

    assign a_h        = a[h*HALF_W +: HALF_W];
    assign b_straight = b[h*HALF_W +: HALF_W];
    assign b_cross    = b[OPP*HALF_W +: HALF_W];
    assign b_sel      = xchg ? b_cross : b_straight;

    assign ea = {a_h[HALF_W-1], a_h};
    assign eb = {b_sel[HALF_W-1], b_sel};
    assign exact = sub[h] ? (ea - eb) : (ea + eb);

    assign res[h*HALF_W +: HALF_W] = exact[HALF_W-1:0];
    assign ge[h*BYTES_PER_HALF +: BYTES_PER_HALF] = {BYTES_PER_HALF{~exact[HALF_W]}};
  end

endmodule

// File: rtl/simd_byte_path.sv
module simd_byte_path #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NUM_BYTE = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic                sub,
  output logic [DATA_W-1:0]   res,
  output logic [NUM_BYTE-1:0] ge
);

  for (genvar k = 0; k < NUM_BYTE; k++) begin : g_lane
    logic [LANE_W-1:0] a_k, b_k;
    logic [LANE_W:0]   ea, eb, exact;

    assign a_k = a[k*LANE_W +: LANE_W];
    assign b_k = b[k*LANE_W +: LANE_W];
    assign ea  = {a_k[LANE_W-1], a_k};
    assign eb  = {b_k[LANE_W-1], b_k};
    assign exact = sub ? (ea - eb) : (ea + eb);

    assign res[k*LANE_W +: LANE_W] = exact[LANE_W-1:0];
    assign ge[k] = ~exact[LANE_W];
  end

endmodule

// File: rtl/psimd_addsub_unit.sv
module psimd_addsub_unit
  import simd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NUM_BYTE = DATA_W / LANE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                exec_en,
  input  logic [2:0]          op,
  input  logic [DATA_W-1:0]   opnd_a,
  input  logic [DATA_W-1:0]   opnd_b,
  output logic [DATA_W-1:0]   res_q,
  output logic [NUM_BYTE-1:0] ge_q
);

  simd_ctrl_t          ctrl;
  logic [DATA_W-1:0]   half_res, byte_res, next_res;
  logic [NUM_BYTE-1:0] half_ge, byte_ge, next_ge;

  simd_op_decode u_dec (
    .op   (op),
    .ctrl (ctrl)
  );

  simd_half_path #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_half (
    .a    (opnd_a),
    .b    (opnd_b),
    .xchg (ctrl.xchg),
    .sub  (ctrl.half_sub),
    .res  (half_res),
    .ge   (half_ge)
  );

  simd_byte_path #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_byte (
    .a   (opnd_a),
    .b   (opnd_b),
    .sub (ctrl.byte_sub),
    .res (byte_res),
    .ge  (byte_ge)
  );

  assign next_res = ctrl.byte_mode ? byte_res : half_res;
  assign next_ge  = ctrl.byte_mode ? byte_ge  : half_ge;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      ge_q  <= '0;
    end else if (exec_en && ctrl.valid) begin
      res_q <= next_res;
      ge_q  <= next_ge;
    end
  end

endmodule

// File: rtl/simd_addsub_checker.sv
module simd_addsub_checker #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NUM_BYTE = DATA_W / LANE_W,
  localparam int HALF_W = DATA_W / 2,
  localparam int HG = NUM_BYTE / 2
) (
  input logic                clk,
  input logic                rst,
  input logic                exec_en,
  input logic [2:0]          op,
  input logic [DATA_W-1:0]   opnd_a,
  input logic [DATA_W-1:0]   opnd_b,
  input logic [DATA_W-1:0]   res_q,
  input logic [NUM_BYTE-1:0] ge_q
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (res_q == '0 && ge_q == '0));

  assert_half_add_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op == 3'd0) |=>
      res_q[HALF_W-1:0] == $past(opnd_a[HALF_W-1:0] + opnd_b[HALF_W-1:0]));

  assert_byte_sub_equal_R7: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op == 3'd7 && opnd_a == opnd_b) |=>
      (res_q == '0 && ge_q == {NUM_BYTE{1'b1}}));

  assert_half_ge_pair_R8: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op <= 3'd3) |=>
      ((ge_q[HG-1:0] == '0 || ge_q[HG-1:0] == {HG{1'b1}}) &&
       (ge_q[NUM_BYTE-1:HG] == '0 || ge_q[NUM_BYTE-1:HG] == {HG{1'b1}})));

  assert_hold_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> ($stable(res_q) && $stable(ge_q)));

  assert_hold_reserved_R11: assert property (@(posedge clk) disable iff (rst)
    (exec_en && (op == 3'd5 || op == 3'd6)) |=> ($stable(res_q) && $stable(ge_q)));

endmodule

bind psimd_addsub_unit simd_addsub_checker #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .exec_en (exec_en),
  .op      (op),
  .opnd_a  (opnd_a),
  .opnd_b  (opnd_b),
  .res_q   (res_q),
  .ge_q    (ge_q)
);

// File: tb/tb_psimd_addsub_unit.sv
module tb_psimd_addsub_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        exec_en;
  logic [2:0]  op;
  logic [31:0] opnd_a, opnd_b;
  logic [31:0] res_q;
  logic [3:0]  ge_q;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] exp_res;
  logic [3:0]  exp_ge;

  psimd_addsub_unit dut (
    .clk     (clk),
    .rst     (rst),
    .exec_en (exec_en),
    .op      (op),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .res_q   (res_q),
    .ge_q    (ge_q)
  );

  always #4 clk = ~clk;

  // Reference built from the lane equations in the requirements.
  function automatic logic [35:0] model(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    int lo, hi, al, ah, bl, bh;
    logic [31:0] r;
    logic [3:0]  g;
    r = '0;
    g = '0;
    al = int'($signed(a[15:0]));  ah = int'($signed(a[31:16]));
    bl = int'($signed(b[15:0]));  bh = int'($signed(b[31:16]));
    if (c <= 3'd3) begin
      case (c)
        3'd0:    begin lo = al + bl; hi = ah + bh; end
        3'd1:    begin lo = al - bh; hi = ah + bl; end
        3'd2:    begin lo = al + bh; hi = ah - bl; end
        default: begin lo = al - bl; hi = ah - bh; end
      endcase
      r = {hi[15:0], lo[15:0]};
      g = {{2{hi >= 0}}, {2{lo >= 0}}};
    end else begin
      for (int k = 0; k < 4; k++) begin
        int x, y, s;
        x = int'($signed(a[k*8 +: 8]));
        y = int'($signed(b[k*8 +: 8]));
        s = (c == 3'd7) ? x - y : x + y;
        r[k*8 +: 8] = s[7:0];
        g[k] = (s >= 0);
      end
    end
    return {g, r};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got_r, input logic [3:0] got_g,
                     input logic [31:0] want_r, input logic [3:0] want_g);
    n_checks++;
    if (got_r !== want_r || got_g !== want_g) begin
      n_fail++;
      $display("FAIL %s: res=%h ge=%b expected res=%h ge=%b", tag, got_r, got_g, want_r, want_g);
    end
  endtask

  // Drive one operation at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic apply(input logic en, input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    logic [35:0] m;
    @(negedge clk);
    exec_en = en; op = c; opnd_a = a; opnd_b = b;
    if (en && c != 3'd5 && c != 3'd6) begin
      m = model(c, a, b);
      exp_res = m[31:0];
      exp_ge  = m[35:32];
    end
    @(negedge clk);
    exec_en = 1'b0;
  endtask

  task automatic run_and_check(input string tag, input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    apply(1'b1, c, a, b);
    chk(tag, res_q, ge_q, exp_res, exp_ge);
  endtask

  task automatic t_reset;
    apply(1'b1, 3'd0, 32'h1234_5678, 32'h1111_1111);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    exp_res = '0; exp_ge = '0;
    chk("R1 reset clears", res_q, ge_q, 32'h0, 4'h0);
  endtask

  task automatic t_half_add;
    run_and_check("R2 halfword add", 3'd0, 32'h1234_0100, 32'h0001_0200);
    // low: -32768 + -1 overflows, exact negative; high: 32767 + 1 wraps, exact positive
    run_and_check("R2/R8 halfword add overflow", 3'd0, 32'h7FFF_8000, 32'h0001_FFFF);
    chk("R8 flags follow exact sign", res_q, ge_q, 32'h8000_7FFF, 4'b1100);
  endtask

  task automatic t_half_sub;
    run_and_check("R3 halfword sub", 3'd3, 32'h0005_0003, 32'h0007_0003);
    run_and_check("R3/R8 halfword sub overflow", 3'd3, 32'h8000_7FFF, 32'h0001_FFFF);
  endtask

  task automatic t_xchg;
    run_and_check("R4 exchange subtract-low", 3'd1, 32'h0010_0020, 32'h0030_0004);
    run_and_check("R4 exchange subtract-low negative", 3'd1, 32'hFFF0_0001, 32'h0002_0005);
    run_and_check("R5 exchange add-low", 3'd2, 32'h0010_0020, 32'h0030_0004);
    run_and_check("R5 exchange add-low overflow", 3'd2, 32'h8000_7FFF, 32'h0001_0001);
  endtask

  task automatic t_byte;
    run_and_check("R6 byte add", 3'd4, 32'h7F80_01FF, 32'h0180_FF01);
    run_and_check("R6/R9 byte add mixed", 3'd4, 32'h80_10_F0_40, 32'hFF_F0_05_40);
    run_and_check("R7 byte sub", 3'd7, 32'h80_7F_00_05, 32'h01_FF_01_05);
    run_and_check("R7/R9 byte sub equal", 3'd7, 32'hA5A5_5A5A, 32'hA5A5_5A5A);
    chk("R9 all flags set on zero lanes", res_q, ge_q, 32'h0, 4'hF);
  endtask

  task automatic t_disabled;
    logic [31:0] r0; logic [3:0] g0;
    run_and_check("R10 preload", 3'd0, 32'h0102_0304, 32'h0000_0001);
    r0 = res_q; g0 = ge_q;
    apply(1'b0, 3'd7, 32'hFFFF_FFFF, 32'h0101_0101);
    chk("R10 disabled byte sub ignored", res_q, ge_q, r0, g0);
    apply(1'b0, 3'd1, 32'h8000_8000, 32'h7FFF_7FFF);
    chk("R10 disabled exchange ignored", res_q, ge_q, r0, g0);
  endtask

  task automatic t_reserved;
    logic [31:0] r0; logic [3:0] g0;
    run_and_check("R11 preload", 3'd7, 32'h0000_0000, 32'h0102_0304);
    r0 = res_q; g0 = ge_q;
    apply(1'b1, 3'd5, 32'h1111_1111, 32'h2222_2222);
    chk("R11 code 5 ignored", res_q, ge_q, r0, g0);
    apply(1'b1, 3'd6, 32'h3333_3333, 32'h4444_4444);
    chk("R11 code 6 ignored", res_q, ge_q, r0, g0);
  endtask

  task automatic t_latency;
    logic [31:0] r0; logic [3:0] g0;
    logic [35:0] m;
    r0 = res_q; g0 = ge_q;
    @(negedge clk);
    exec_en = 1'b1; op = 3'd3; opnd_a = 32'h0000_0000; opnd_b = 32'h0001_0001;
    m = model(3'd3, 32'h0000_0000, 32'h0001_0001);
    #1;
    chk("R12 not visible before edge", res_q, ge_q, r0, g0);
    @(negedge clk);
    exec_en = 1'b0;
    exp_res = m[31:0]; exp_ge = m[35:32];
    chk("R12 visible after one edge", res_q, ge_q, exp_res, exp_ge);
  endtask

  initial begin
    rst = 1'b1; exec_en = 1'b0; op = '0; opnd_a = '0; opnd_b = '0;
    exp_res = '0; exp_ge = '0;
    repeat (3) @(negedge clk);
    chk("R1 state during reset", res_q, ge_q, 32'h0, 4'h0);
    rst = 1'b0;
    t_reset();
    t_half_add();
    t_half_sub();
    t_xchg();
    t_byte();
    t_disabled();
    t_reserved();
    t_latency();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule